// File: doc/BRIEF.md
# DRAM Training Pattern Engine

This block runs the data-pattern part of DRAM training under register control. Software first loads a pattern buffer one dword at a time through a data register whose dword pointer advances by itself. It then starts a write run, which sends a programmed number of cache lines from the buffer to consecutive DRAM line addresses. A later read run fetches the same lines back, compares each line with the buffer contents, and keeps a sticky error map with one bit per byte lane.

Each kind of run has its own mode bit and its own go bit. A go bit is accepted only when the matching mode bit is set in the same control write. It reads as 1 while its run is in progress and clears by itself when the run finishes. There are two status registers with the same lane layout. A select bit in the control register picks which one a read run clears and fills, so the result of one comparison pass can be kept while a second pass runs. A status bit of 1 means the lane failed, so the pass map is the bitwise inverse of the status.

The register map uses word offsets: 0 control, 1 run length, 2 buffer dword pointer, 3 buffer data, 4 line address low, 5 line address high, 6 status A, 7 status B. The control bits are: 0 write mode, 1 read mode, 2 write go, 3 read go, 4 status select. The DRAM side moves one 512-bit line per request. A write request is taken in the cycle it is raised. A read request is answered by a later cycle with `dram_rvalid` high.

Top module: `dram_train_engine`

## Requirements
- R1: After reset, every register reads 0 and `dram_req` is low.
- R2: A write to offset 2 sets the buffer dword pointer. Each write to offset 3 stores the dword at the pointer and then adds one to the pointer. The line is pointer bits [9:4] and the word is bits [3:0]. Dword w of a line occupies line bits 32w+31:32w. Offset 2 reads back the pointer.
- R3: A control write with bits 0 and 2 both set starts a write run. The run sends buffer lines 0 to n-1, one line per cycle in back-to-back cycles, with line i going to address base+i. The base is {offset 5 bits [1:0], offset 4 bits [31:0]}.
- R4: Control bit 2 (or bit 3) reads 1 while its run is in progress and reads 0 once the run ends.
- R5: A control write with bits 1 and 3 both set starts a read run. The run requests lines base+i in order and compares each returned line with buffer line i.
- R6: Status bit k is set when byte k of any 64-bit beat of any compared line differs. Beat b is line bits 64b+63:64b. Status bits 31:8 read 0.
- R7: A read run clears the selected status at its start. During the run, error bits stay set once set, across all lines.
- R8: Control bit 4 selects the status register: 0 selects offset 6 and 1 selects offset 7. The other status register is left unchanged.
- R9: A go bit written while the matching mode bit is clear in the same write is ignored. No DRAM access follows.
- R10: If a single control write sets both modes and both go bits, only the write run starts.
- R11: Register writes made while a run is in progress are ignored.
- R12: The run length n is the value at offset 1, limited to the buffer size of 64 lines. A length of 0 makes no DRAM access and leaves both go bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| dram_req | output | 1 | Line request valid |
| dram_we | output | 1 | 1 = line write, 0 = line read |
| dram_addr | output | 34 | Line address (64-byte units) |
| dram_wdata | output | 512 | Line write data |
| dram_rvalid | input | 1 | Read data return valid |
| dram_rdata | input | 512 | Returned line |

## Verification
Two things can land in the same cycle. One is a control write that carries both go bits, where the write run and the read run compete to start. The other is a register write that arrives while a run is still in progress. The bench provokes the first with a single control write of both modes and both go bits, and judges it by counting DRAM writes against DRAM reads. It provokes the second by writing the address, length, pointer, data and control registers during a 64-line read run. It then reads each register back and reruns the comparison, expecting unchanged values and a clean status.

// File: rtl/train_pkg.sv
package train_pkg;
  localparam int DW        = 32;
  localparam int WSEL_W    = 4;
  localparam int LINE_W    = 512;
  localparam int BEAT_W    = 64;
  localparam int BEATS     = LINE_W / BEAT_W;
  localparam int LANES     = BEAT_W / 8;
  localparam int AHI_W     = 2;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_LEN   = 3'd1;
  localparam logic [2:0] RA_BPTR  = 3'd2;
  localparam logic [2:0] RA_BDATA = 3'd3;
  localparam logic [2:0] RA_ALO   = 3'd4;
  localparam logic [2:0] RA_AHI   = 3'd5;
  localparam logic [2:0] RA_STSA  = 3'd6;
  localparam logic [2:0] RA_STSB  = 3'd7;

  localparam int CB_WRM = 0;
  localparam int CB_RDM = 1;
  localparam int CB_WGO = 2;
  localparam int CB_RGO = 3;
  localparam int CB_SEL = 4;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WRITE, SQ_RREQ, SQ_RWAIT} seq_state_e;

  function automatic int unsigned lane_byte_lsb(int unsigned beat, int unsigned lane);
    return beat * BEAT_W + lane * 8;
  endfunction
endpackage

// File: rtl/tpg_buffer.sv
module tpg_buffer import train_pkg::*; #(
  parameter int BUF_LINES = 64,
  parameter int LIDX_W    = $clog2(BUF_LINES),
  parameter int PTR_W     = LIDX_W + WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_val,
  input  logic              push,
  input  logic [DW-1:0]     push_data,
  input  logic [LIDX_W-1:0] rd_idx,
  output logic [LINE_W-1:0] rd_line,
  output logic [PTR_W-1:0]  ptr
);
  logic [LINE_W-1:0] mem [BUF_LINES];
  logic [LIDX_W-1:0] wr_line;
  logic [WSEL_W-1:0] wr_word;

  assign wr_line = ptr[PTR_W-1:WSEL_W];
  assign wr_word = ptr[WSEL_W-1:0];

  always_ff @(posedge clk) begin
    if (push) mem[wr_line][{wr_word, 5'b0} +: DW] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (ptr_load) ptr <= ptr_val;
    else if (push)     ptr <= ptr + PTR_W'(1);
  end

  assign rd_line = mem[rd_idx];
endmodule

// File: rtl/tpg_lane_cmp.sv
module tpg_lane_cmp import train_pkg::*; (
  input  logic [LINE_W-1:0] got,
  input  logic [LINE_W-1:0] want,
  output logic [LANES-1:0]  lane_err
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int b = 0; b < BEATS; b++) begin
        if (got[lane_byte_lsb(b, k) +: 8] != want[lane_byte_lsb(b, k) +: 8]) hit = 1'b1;
      end
    end
    assign lane_err[k] = hit;
  end
endmodule

// File: rtl/tpg_seq.sv
module tpg_seq import train_pkg::*; #(
  parameter int LIDX_W = 6,
  parameter int LEN_W  = LIDX_W + 1,
  parameter int AW     = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [LEN_W-1:0]  run_len,
  input  logic [AW-1:0]     base,
  input  logic              rvalid,
  output logic              wr_busy,
  output logic              rd_busy,
  output logic [LIDX_W-1:0] line_idx,
  output logic              dram_req,
  output logic              dram_we,
  output logic [AW-1:0]     dram_addr,
  output logic              cmp_fire,
  output logic              run_done
);
  seq_state_e        state;
  logic [LEN_W-1:0]  len_q;
  logic [AW-1:0]     base_q;
  logic              last;

  function automatic logic [AW-1:0] line_addr(input logic [AW-1:0] b, input logic [LIDX_W-1:0] i);
    return b + AW'(i);
  endfunction

  assign last = (LEN_W'(line_idx) == len_q - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      line_idx <= '0;
      len_q    <= '0;
      base_q   <= '0;
    end else begin
      case (state)
        SQ_IDLE: if ((start_wr || start_rd) && run_len != '0) begin
          line_idx <= '0;
          len_q    <= run_len;
          base_q   <= base;
          state    <= start_wr ? SQ_WRITE : SQ_RREQ;
        end
        SQ_WRITE: begin
          if (last) state <= SQ_IDLE;
          else      line_idx <= line_idx + LIDX_W'(1);
        end
        SQ_RREQ: state <= SQ_RWAIT;
        SQ_RWAIT: if (rvalid) begin
          if (last) state <= SQ_IDLE;
          else begin
            line_idx <= line_idx + LIDX_W'(1);
            state    <= SQ_RREQ;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign wr_busy   = (state == SQ_WRITE);
  assign rd_busy   = (state == SQ_RREQ) || (state == SQ_RWAIT);
  assign dram_req  = (state == SQ_WRITE) || (state == SQ_RREQ);
  assign dram_we   = (state == SQ_WRITE);
  assign dram_addr = line_addr(base_q, line_idx);
  assign cmp_fire  = (state == SQ_RWAIT) && rvalid;
  assign run_done  = ((state == SQ_WRITE) && last) || (cmp_fire && last);
endmodule

// File: rtl/dram_train_engine.sv
module dram_train_engine import train_pkg::*; #(
  parameter int BUF_LINES = 64,
  parameter int ADDR_LO_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [2:0]                 reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       dram_req,
  output logic                       dram_we,
  output logic [ADDR_LO_W+AHI_W-1:0] dram_addr,
  output logic [LINE_W-1:0]          dram_wdata,
  input  logic                       dram_rvalid,
  input  logic [LINE_W-1:0]          dram_rdata
);
  localparam int LIDX_W = $clog2(BUF_LINES);
  localparam int LEN_W  = LIDX_W + 1;
  localparam int PTR_W  = LIDX_W + WSEL_W;
  localparam int AW     = ADDR_LO_W + AHI_W;

  logic                 ctrl_wrm, ctrl_rdm, ctrl_sel;
  logic [LEN_W-1:0]     len_q;
  logic [ADDR_LO_W-1:0] alo_q;
  logic [AHI_W-1:0]     ahi_q;
  logic [LANES-1:0]     sts_a, sts_b;

  logic wr_busy, rd_busy, run_busy, run_done, cmp_fire;
  logic reg_take, ctrl_write, buf_push, ptr_load, start_wr, start_rd;
  logic [LIDX_W-1:0] line_idx;
  logic [PTR_W-1:0]  buf_ptr;
  logic [LINE_W-1:0] buf_line;
  logic [LANES-1:0]  lane_err;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    return (l > LEN_W'(BUF_LINES)) ? LEN_W'(BUF_LINES) : l;
  endfunction

  assign run_busy   = wr_busy || rd_busy;
  assign reg_take   = reg_wr && !run_busy;
  assign ctrl_write = reg_take && (reg_addr == RA_CTRL);
  assign buf_push   = reg_take && (reg_addr == RA_BDATA);
  assign ptr_load   = reg_take && (reg_addr == RA_BPTR);
  assign start_wr   = ctrl_write && reg_wdata[CB_WRM] && reg_wdata[CB_WGO];
  assign start_rd   = ctrl_write && reg_wdata[CB_RDM] && reg_wdata[CB_RGO] && !start_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_wrm <= 1'b0;
      ctrl_rdm <= 1'b0;
      ctrl_sel <= 1'b0;
      len_q    <= '0;
      alo_q    <= '0;
      ahi_q    <= '0;
    end else if (reg_take) begin
      case (reg_addr)
        RA_CTRL: begin
          ctrl_wrm <= reg_wdata[CB_WRM];
          ctrl_rdm <= reg_wdata[CB_RDM];
          ctrl_sel <= reg_wdata[CB_SEL];
        end
        RA_LEN:  len_q <= reg_wdata[LEN_W-1:0];
        RA_ALO:  alo_q <= reg_wdata[ADDR_LO_W-1:0];
        RA_AHI:  ahi_q <= reg_wdata[AHI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_a <= '0;
      sts_b <= '0;
    end else if (start_rd) begin
      if (reg_wdata[CB_SEL]) sts_b <= '0;
      else                   sts_a <= '0;
    end else if (cmp_fire) begin
      if (ctrl_sel) sts_b <= sts_b | lane_err;
      else          sts_a <= sts_a | lane_err;
    end
  end

  tpg_buffer #(.BUF_LINES(BUF_LINES), .LIDX_W(LIDX_W), .PTR_W(PTR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_val(reg_wdata[PTR_W-1:0]),
    .push(buf_push), .push_data(reg_wdata), .rd_idx(line_idx), .rd_line(buf_line),
    .ptr(buf_ptr)
  );

  tpg_seq #(.LIDX_W(LIDX_W), .LEN_W(LEN_W), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
    .run_len(clamp_len(len_q)), .base({ahi_q, alo_q}), .rvalid(dram_rvalid),
    .wr_busy(wr_busy), .rd_busy(rd_busy), .line_idx(line_idx), .dram_req(dram_req),
    .dram_we(dram_we), .dram_addr(dram_addr), .cmp_fire(cmp_fire), .run_done(run_done)
  );

  tpg_lane_cmp u_cmp (.got(dram_rdata), .want(buf_line), .lane_err(lane_err));

  assign dram_wdata = buf_line;

  always_comb begin
    case (reg_addr)
      RA_CTRL:  reg_rdata = 32'({ctrl_sel, rd_busy, wr_busy, ctrl_rdm, ctrl_wrm});
      RA_LEN:   reg_rdata = 32'(len_q);
      RA_BPTR:  reg_rdata = 32'(buf_ptr);
      RA_ALO:   reg_rdata = 32'(alo_q);
      RA_AHI:   reg_rdata = 32'(ahi_q);
      RA_STSA:  reg_rdata = 32'(sts_a);
      RA_STSB:  reg_rdata = 32'(sts_b);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tpg_chk.sv
module tpg_chk #(
  parameter int PTR_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_busy,
  input logic             rd_busy,
  input logic             dram_req,
  input logic             dram_we,
  input logic             run_done,
  input logic             buf_push,
  input logic [PTR_W-1:0] buf_ptr,
  input logic             ctrl_sel,
  input logic [7:0]       sts_a,
  input logic [7:0]       sts_b
);
  AST_ONE_RUN_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_busy && rd_busy)); // R10
  AST_WRITE_ONLY_IN_WRITE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_req && dram_we) |-> wr_busy); // R3
  AST_READ_ONLY_IN_READ_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_req && !dram_we) |-> rd_busy); // R5
  AST_WRITES_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && !run_done) |=> (dram_req && dram_we)); // R3
  AST_GO_CLEARS_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |=> !(wr_busy || rd_busy)); // R4
  AST_PTR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    buf_push |=> (buf_ptr == $past(buf_ptr) + PTR_W'(1))); // R2
  AST_STS_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && $past(rd_busy)) |-> ((sts_a & $past(sts_a)) == $past(sts_a))); // R7
  AST_STS_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && $past(rd_busy)) |-> ((sts_b & $past(sts_b)) == $past(sts_b))); // R7
  AST_UNSELECTED_A_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && ctrl_sel) |-> $stable(sts_a)); // R8
  AST_UNSELECTED_B_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !ctrl_sel) |-> $stable(sts_b)); // R8
endmodule

bind dram_train_engine tpg_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_busy(wr_busy), .rd_busy(rd_busy),
  .dram_req(dram_req), .dram_we(dram_we), .run_done(run_done),
  .buf_push(buf_push), .buf_ptr(buf_ptr), .ctrl_sel(ctrl_sel),
  .sts_a(sts_a), .sts_b(sts_b)
);

// File: tb/tb_dram_train_engine.sv
`timescale 1ns/1ps
module tb_dram_train_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = 3'd0;
  logic [31:0]  reg_wdata = 32'd0;
  logic [31:0]  reg_rdata;
  logic         dram_req, dram_we;
  logic [33:0]  dram_addr;
  logic [511:0] dram_wdata;
  logic         dram_rvalid;
  logic [511:0] dram_rdata;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_train_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dram_req(dram_req),
    .dram_we(dram_we), .dram_addr(dram_addr), .dram_wdata(dram_wdata),
    .dram_rvalid(dram_rvalid), .dram_rdata(dram_rdata)
  );

  // DRAM model: 256 lines indexed by the low address byte, read latency 2
  logic [511:0] dmem [256];
  logic [33:0]  wlog [1024];
  logic [33:0]  rlog [1024];
  int           wcyc [1024];
  int           wr_total = 0;
  int           rd_total = 0;
  logic         p1_v = 1'b0, p2_v = 1'b0;
  logic [7:0]   p1_a = 8'd0;
  logic [511:0] p2_d = '0;

  always @(posedge clk) begin
    if (dram_req && dram_we) begin
      dmem[dram_addr[7:0]] <= dram_wdata;
      wlog[wr_total % 1024] <= dram_addr;
      wcyc[wr_total % 1024] <= cyc;
      wr_total <= wr_total + 1;
    end
    if (dram_req && !dram_we) begin
      rlog[rd_total % 1024] <= dram_addr;
      rd_total <= rd_total + 1;
      p1_v <= 1'b1;
      p1_a <= dram_addr[7:0];
    end else begin
      p1_v <= 1'b0;
    end
    p2_v <= p1_v;
    p2_d <= dmem[p1_a];
  end
  assign dram_rvalid = p2_v;
  assign dram_rdata  = p2_d;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int guard = 0;
    do begin
      reg_read(3'd0, v);
      guard++;
    end while ((v & 32'hC) != 0 && guard < 5000);
  endtask

  function automatic logic [31:0] pat(int line, int word, int seed);
    logic [7:0] l8, w8, s8;
    l8 = 8'(line); w8 = 8'(word); s8 = 8'(seed);
    return {s8, l8, w8, s8 ^ l8 ^ w8};
  endfunction

  function automatic logic [511:0] exp_line(int line, int seed);
    logic [511:0] r;
    for (int w = 0; w < 16; w++) r[w*32 +: 32] = pat(line, w, seed);
    return r;
  endfunction

  task automatic load_pattern(input int n, input int seed);
    reg_write(3'd2, 32'd0);
    for (int i = 0; i < n; i++)
      for (int w = 0; w < 16; w++) reg_write(3'd3, pat(i, w, seed));
  endtask

  task automatic write_run(input int len, input int seed, input logic [31:0] lo, input logic [1:0] hi);
    int eff, s;
    logic [31:0] v;
    logic [33:0] base;
    bit addr_ok, data_ok;
    eff = (len > 64) ? 64 : len;
    base = {hi, lo};
    reg_write(3'd4, lo);
    reg_write(3'd5, 32'(hi));
    reg_write(3'd1, 32'(len));
    load_pattern(eff, seed);
    s = wr_total;
    reg_write(3'd0, 32'h5);
    reg_read(3'd0, v);
    check(eff < 3 || v[2] == 1'b1, "R4 write go reads 1 while running", 64'(v), 64'h5);
    wait_idle();
    reg_read(3'd0, v);
    check(v[3:2] == 2'b00, "R4 write go cleared after run", 64'(v), 64'h1);
    check(wr_total - s == eff, "R12/R3 number of lines written", 64'(wr_total - s), 64'(eff));
    addr_ok = 1'b1; data_ok = 1'b1;
    for (int k = 0; k < eff; k++) begin
      if (wlog[(s + k) % 1024] != base + 34'(k)) addr_ok = 1'b0;
      if (dmem[8'(base[7:0] + 8'(k))] != exp_line(k, seed)) data_ok = 1'b0;
    end
    check(addr_ok, "R3 write addresses base+i", 64'(wlog[s % 1024]), 64'(base));
    check(data_ok, "R2/R3 line data from buffer", 64'(data_ok), 64'd1);
    check(wcyc[(s + eff - 1) % 1024] - wcyc[s % 1024] == eff - 1, "R3 back-to-back writes",
          64'(wcyc[(s + eff - 1) % 1024] - wcyc[s % 1024]), 64'(eff - 1));
    reg_write(3'd0, 32'h0);
  endtask

  logic [7:0] exp_a = 8'd0, exp_b = 8'd0;

  task automatic read_run(input int n, input bit sel, input logic [7:0] exp_sts, input logic [33:0] base);
    int s;
    bit addr_ok;
    logic [31:0] va, vb;
    s = rd_total;
    reg_write(3'd0, 32'hA | (32'(sel) << 4));
    wait_idle();
    check(rd_total - s == n, "R5 number of lines read", 64'(rd_total - s), 64'(n));
    addr_ok = 1'b1;
    for (int k = 0; k < n; k++) if (rlog[(s + k) % 1024] != base + 34'(k)) addr_ok = 1'b0;
    check(addr_ok, "R5 read addresses base+i", 64'(rlog[s % 1024]), 64'(base));
    if (sel) exp_b = exp_sts; else exp_a = exp_sts;
    reg_read(3'd6, va);
    reg_read(3'd7, vb);
    check(va == 32'(exp_a), "R6/R7/R8 status A", 64'(va), 64'(exp_a));
    check(vb == 32'(exp_b), "R6/R7/R8 status B", 64'(vb), 64'(exp_b));
    reg_write(3'd0, 32'h0);
  endtask

  task automatic flip(input int a, input int beat, input int lane);
    int b;
    b = beat * 64 + lane * 8;
    dmem[a][b] = ~dmem[a][b];
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", fails, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s, sr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      reg_read(3'(a), v);
      check(v == 32'd0, "R1 register zero after reset", 64'(v), 64'd0);
    end
    check(dram_req == 1'b0, "R1 no DRAM request after reset", 64'(dram_req), 64'd0);

    // R2 pointer load and auto-advance
    reg_write(3'd2, 32'h13);
    reg_write(3'd3, 32'h1);
    reg_write(3'd3, 32'h2);
    reg_write(3'd3, 32'h3);
    reg_read(3'd2, v);
    check(v == 32'h16, "R2 pointer advances per data write", 64'(v), 64'h16);

    // R9 go without mode ignored
    reg_write(3'd1, 32'd4);
    s = wr_total; sr = rd_total;
    reg_write(3'd0, 32'hC);
    repeat (10) @(negedge clk);
    reg_read(3'd0, v);
    check(v == 32'd0, "R9 go without mode ignored (ctrl)", 64'(v), 64'd0);
    check(wr_total == s && rd_total == sr, "R9 no DRAM access", 64'(wr_total - s + rd_total - sr), 64'd0);

    // single line and five-line runs
    write_run(1, 1, 32'h10, 2'd0);
    read_run(1, 1'b0, 8'h00, 34'h10);
    write_run(5, 2, 32'h20, 2'd1);
    read_run(5, 1'b0, 8'h00, {2'd1, 32'h20});

    // R6 lane sweep, one corrupted byte at a time, alternating status select
    for (int k = 0; k < 8; k++) begin
      flip(8'h20 + k % 5, 7 - k, k);
      read_run(5, k[0], 8'(1 << k), {2'd1, 32'h20});
      flip(8'h20 + k % 5, 7 - k, k);
    end

    // R7 sticky across lines, cleared at next start
    flip(8'h20, 0, 1);
    flip(8'h24, 5, 6);
    read_run(5, 1'b0, 8'h42, {2'd1, 32'h20});
    flip(8'h20, 0, 1);
    flip(8'h24, 5, 6);
    read_run(5, 1'b0, 8'h00, {2'd1, 32'h20});

    // R10 both modes and both go bits: only the write run
    s = wr_total; sr = rd_total;
    reg_write(3'd0, 32'hF);
    wait_idle();
    check(wr_total - s == 5, "R10 write run started", 64'(wr_total - s), 64'd5);
    check(rd_total == sr, "R10 read go ignored", 64'(rd_total - sr), 64'd0);
    reg_write(3'd0, 32'h0);

    // R12 clamp to buffer size
    write_run(100, 3, 32'h40, 2'd2);
    read_run(64, 1'b1, 8'h00, {2'd2, 32'h40});

    // R11 register writes during a read run are ignored
    reg_write(3'd0, 32'hA);
    reg_write(3'd4, 32'hDEAD);
    reg_write(3'd1, 32'd3);
    reg_write(3'd2, 32'd5);
    reg_write(3'd3, 32'h0);
    reg_write(3'd0, 32'h0);
    wait_idle();
    reg_read(3'd4, v);
    check(v == 32'h40, "R11 address low unchanged", 64'(v), 64'h40);
    reg_read(3'd1, v);
    check(v == 32'd100, "R11 length unchanged", 64'(v), 64'd100);
    reg_read(3'd2, v);
    check(v == 32'd0, "R11 pointer unchanged", 64'(v), 64'd0);
    reg_read(3'd0, v);
    check(v == 32'h2, "R11 control unchanged", 64'(v), 64'h2);
    read_run(64, 1'b0, 8'h00, {2'd2, 32'h40});

    // R12 zero length
    reg_write(3'd1, 32'd0);
    s = wr_total;
    reg_write(3'd0, 32'h5);
    reg_read(3'd0, v);
    check(v[3:2] == 2'b00, "R12 zero length go stays 0", 64'(v), 64'h1);
    repeat (5) @(negedge clk);
    check(wr_total == s, "R12 zero length no DRAM access", 64'(wr_total - s), 64'd0);

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule